// File: doc/BRIEF.md
# ATA I/O Strobe Timing Generator

This block turns one access request from a card-side bus into a single timed host strobe toward an ATA device. A bus-control register sets the timing. An access waits a programmable number of ticks, then raises one strobe. The strobe stays high for a fixed minimum plus a programmable extra width. After that it stays high for as long as the device keeps its ready line low. All of this timing is counted on a tick that fires on every second master clock.

A mapping bit in the same register decides how memory-space accesses leave the block. They either use the I/O read/write strobes or a separate pair of memory read/write strobes. I/O-space accesses always use the I/O strobes. Each access captures the timing fields and the mapping bit when it is accepted. A register write made while an access is running therefore only affects later accesses.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset all four strobes, `busy` and `done` are low. The access-delay and width fields are zero, so the first access rises within 1 to 2 clocks of acceptance and its strobe is high for exactly 6 clocks.
- R2: The tick fires on every second clock after reset. Strobe edges happen only on tick edges, so with `dev_rdy` high every strobe lasts an even number of clocks.
- R3: With `dev_rdy` high, the strobe is high for exactly 2*(3+W) clocks. W is the width field, bits 5:4 of the control register.
- R4: The strobe rises n clocks after the acceptance edge, where n is 2D+1 or 2D+2. D is the delay field, bits 7:6 of the control register.
- R5: Each tick on which `dev_rdy` is low, sampled once the 3+W minimum ticks are over, adds one tick (2 clocks) to the strobe. The strobe falls on the first tick with `dev_rdy` high.
- R6: `dev_rdy` low during the delay phase or during the first 3+W ticks of the strobe does not change the strobe length.
- R7: Control register bit 3 is the mapping bit. A memory-space access (`req_mem`=1) drives `io_rd`/`io_wr` when bit 3 is 1 and `mem_rd`/`mem_wr` when bit 3 is 0. An I/O-space access always drives `io_rd`/`io_wr`. `req_write`=1 selects the write strobe.
- R8: The control register is written only when `reg_wr` is high and `reg_addr` equals 8'h2F. Writes to any other address leave the timing unchanged.
- R9: `busy` is high from the clock after acceptance until the strobe falls. A `req` that arrives while `busy` is high is dropped and causes no further access.
- R10: `done` is high for exactly one clock, in the same cycle in which the strobe has just fallen and `busy` has dropped.
- R11: An access uses the register value held at its acceptance edge. A write in the same cycle as acceptance, or any write during the access, only affects the next access.
- R12: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| req | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_mem | input | 1 | 1 = memory-space access, 0 = I/O-space access |
| dev_rdy | input | 1 | Device ready, low stretches the strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |
| io_rd | output | 1 | I/O read strobe, active high |
| io_wr | output | 1 | I/O write strobe, active high |
| mem_rd | output | 1 | Memory read strobe, active high |
| mem_wr | output | 1 | Memory write strobe, active high |

## Verification
Two events can land in the same clock. One is a control-register write together with the acceptance of a request. The other is a new request together with a running strobe, where the bench also writes new timing while the strobe is high. The bench provokes both on purpose and also mixes them into random traffic. It judges the result by the measured rise delay and strobe length of the current access, which must match the timing captured at its acceptance edge. It also checks that the intruding request never starts a second strobe, and that the new value applies only to the next access.

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h2F,
  parameter int MIN_TICKS = 3,
  parameter int FIELD_W = 2,
  parameter int DLY_LSB = 6,
  parameter int WID_LSB = 4,
  parameter int MAP_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              dev_rdy,
  output logic              busy,
  output logic              done,
  output logic              io_rd,
  output logic              io_wr,
  output logic              mem_rd,
  output logic              mem_wr
);

  localparam int CNT_W = $clog2(MIN_TICKS + (1 << FIELD_W)) + 1;

  typedef enum logic [1:0] {IDLE, WAIT, HOLD} state_t;

  state_t             st;
  logic               tick;
  logic [FIELD_W-1:0] dly_cfg, wid_cfg, wid_q;
  logic               map_cfg;
  logic [CNT_W-1:0]   cnt;
  logic               act_wr, act_io, done_q;
  logic               accept, on;
  logic [DATA_W-1:0]  unused_wdata;

  assign unused_wdata = reg_wdata;
  assign accept = (st == IDLE) && req;
  assign on     = (st == HOLD);
  assign busy   = (st != IDLE);
  assign done   = done_q;
  assign io_rd  = on &  act_io & ~act_wr;
  assign io_wr  = on &  act_io &  act_wr;
  assign mem_rd = on & ~act_io & ~act_wr;
  assign mem_wr = on & ~act_io &  act_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly_cfg <= '0;
      wid_cfg <= '0;
      map_cfg <= 1'b0;
    end else if (reg_wr && reg_addr == CTRL_ADDR) begin
      dly_cfg <= reg_wdata[DLY_LSB +: FIELD_W];
      wid_cfg <= reg_wdata[WID_LSB +: FIELD_W];
      map_cfg <= reg_wdata[MAP_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      wid_q  <= '0;
      act_wr <= 1'b0;
      act_io <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          st     <= WAIT;
          cnt    <= CNT_W'(dly_cfg);
          wid_q  <= wid_cfg;
          act_wr <= req_write;
          act_io <= ~req_mem | map_cfg;
        end
        WAIT: if (tick) begin
          if (cnt == '0) begin
            st  <= HOLD;
            cnt <= CNT_W'(MIN_TICKS - 1) + CNT_W'(wid_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        HOLD: if (tick) begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (dev_rdy) begin
            st     <= IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic req,
  input logic busy,
  input logic done,
  input logic io_rd,
  input logic io_wr,
  input logic mem_rd,
  input logic mem_wr
);
  logic [3:0] stb;
  assign stb = {io_rd, io_wr, mem_rd, mem_wr};

  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (stb == 4'b0 && !busy && !done);

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(stb));

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (stb != 4'b0) |-> busy);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && req) |=> busy);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && stb == 4'b0));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(stb != 4'b0) |-> done);

  // R2
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(stb) |-> $past(tick));
endmodule

bind ata_strobe_timer ata_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .busy(busy), .done(done),
  .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/ata_strobe_timer_test.sv
module ata_strobe_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, req = 1'b0, req_write = 1'b0, req_mem = 1'b0, dev_rdy = 1'b1;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic busy, done, io_rd, io_wr, mem_rd, mem_wr;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] cfg = 8'h00;

  always #5 clk = ~clk;

  ata_strobe_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req(req), .req_write(req_write), .req_mem(req_mem), .dev_rdy(dev_rdy),
    .busy(busy), .done(done), .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  function automatic logic [3:0] exp_stb(input bit wr, input bit mem, input logic [7:0] c);
    bit io = !mem || c[3];
    return io ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
  endfunction

  function automatic int exp_len(input logic [7:0] c, input int s);
    return 2 * (3 + int'(c[5:4]) + s);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h2F) cfg = d;
  endtask

  // mode 0: plain, 1: write in acceptance cycle, 2: write + req while strobe high
  task automatic do_access(input bit wr, input bit mem, input int s, input int mode, input logic [7:0] nc);
    logic [7:0] c = cfg;
    logic [3:0] es = exp_stb(wr, mem, c);
    int d = int'(c[7:6]);
    int n = 1, hi = 1;
    @(negedge clk);
    req = 1'b1; req_write = wr; req_mem = mem;
    if (mode == 1) begin reg_wr = 1'b1; reg_addr = 8'h2F; reg_wdata = nc; end
    @(negedge clk);
    req = 1'b0; reg_wr = 1'b0;
    if (mode == 1) cfg = nc;
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    while ({io_rd, io_wr, mem_rd, mem_wr} == 4'b0 && n < 40) begin
      dev_rdy = 1'($urandom);
      @(negedge clk);
      n++;
    end
    chk((n - 1 == 2*d + 1) || (n - 1 == 2*d + 2), "R4/R11 rise delay", n - 1, 2*d + 1);
    dev_rdy = (hi >= exp_len(c, s)) || (hi < exp_len(c, 0) && 1'($urandom));
    while ({io_rd, io_wr, mem_rd, mem_wr} != 4'b0 && hi < 200) begin
      chk({io_rd, io_wr, mem_rd, mem_wr} == es, "R7/R12 strobe select", {io_rd, io_wr, mem_rd, mem_wr}, es);
      req = 1'b0; reg_wr = 1'b0;
      if (mode == 2 && hi == 2) begin
        req = 1'b1; req_write = ~wr; req_mem = ~mem;
        reg_wr = 1'b1; reg_addr = 8'h2F; reg_wdata = nc;
      end
      @(negedge clk);
      if (mode == 2 && hi == 2) cfg = nc;
      if ({io_rd, io_wr, mem_rd, mem_wr} != 4'b0) hi++;
      dev_rdy = (hi >= exp_len(c, s)) || (hi < exp_len(c, 0) && 1'($urandom));
    end
    req = 1'b0; reg_wr = 1'b0;
    chk(hi == exp_len(c, s), (s != 0) ? "R5 stretched length" : "R2/R3/R6 strobe length", hi, exp_len(c, s));
    chk(done === 1'b1 && busy === 1'b0, "R10 done at fall", {done, busy}, 2);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single", done, 0);
    chk(busy === 1'b0 && {io_rd, io_wr, mem_rd, mem_wr} == 4'b0, "R9 dropped request", busy, 0);
    dev_rdy = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1720));
    repeat (4) @(negedge clk);
    chk({io_rd, io_wr, mem_rd, mem_wr, busy, done} == 6'b0, "R1 in reset", {io_rd, io_wr, mem_rd, mem_wr, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({io_rd, io_wr, mem_rd, mem_wr, busy, done} == 6'b0, "R1 after reset", {io_rd, io_wr, mem_rd, mem_wr, busy, done}, 0);
    // R1 defaults: delay 0, width 0
    do_access(1'b0, 1'b0, 0, 0, 8'h00);
    // R8 other address ignored
    wr_reg(8'h2E, 8'hFF);
    do_access(1'b1, 1'b0, 0, 0, 8'h00);
    wr_reg(8'h2F, 8'hF0);
    do_access(1'b1, 1'b1, 0, 0, 8'h00);
    // R7 mapping on
    wr_reg(8'h2F, 8'h58);
    do_access(1'b0, 1'b1, 0, 0, 8'h00);
    do_access(1'b1, 1'b1, 0, 0, 8'h00);
    // R5 stretch
    do_access(1'b0, 1'b0, 3, 0, 8'h00);
    // R11 same-cycle write and acceptance
    do_access(1'b1, 1'b1, 0, 1, 8'hE0);
    do_access(1'b0, 1'b1, 1, 0, 8'h00);
    // R9 R11 write and request during strobe
    do_access(1'b1, 1'b0, 0, 2, 8'h18);
    do_access(1'b1, 1'b1, 0, 0, 8'h00);
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 3 == 0)
        wr_reg(($urandom % 2 == 0) ? 8'h2F : 8'(8'h30 + $urandom % 8), 8'($urandom));
      do_access(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 3), 8'($urandom));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule